// File: doc/BRIEF.md
# Bus-Seeded Serial Pseudo-Random Bit Source

This block produces one pseudo-random bit per clock from a 64-bit linear feedback shift register. The shift register is arranged in Fibonacci form, with the new bit entering at the bottom and the output taken from the top. Its feedback comes from the XOR of bit positions 63, 62, 60 and 59, counting from zero. This tap set gives a maximal-length sequence.

A minimal Wishbone-style write-only slave port loads the starting state. Each accepted transfer carries one 8-bit byte into an eight-entry seed bank, and a 3-bit address selects the entry.

The register holds its value while a bus cycle is open. On the first clock after the cycle closes, it loads the new seed if at least one byte was written during the cycle. From then on it runs freely. An all-zero seed is replaced by a fixed nonzero default, so the generator can never lock up.

Top module: `lfsr_bitgen_wb`

## Requirements
- R1: A synchronous active-high reset sets the register and every seed byte to the default seed 64'hC3A5_5A3C_9E37_79B9 and clears ack and stall. While reset is held, the output bit is bit 63 of the default seed.
- R2: On each clock where cyc is low and no reload is pending, the register shifts one place toward bit 63. The new bit 0 is the XOR of bits 63, 62, 60 and 59. The output bit is always register bit 63.
- R3: A transfer is a write when cyc, stb and we are all 1 on a clock edge. Such a write stores the data byte in seed bits [8*adr+7 : 8*adr].
- R4: ack is 1 during the clock that follows each write, for one clock per write, so back-to-back writes give back-to-back acks. ack is 0 after any clock that carried no write.
- R5: stall is 0 at all times.
- R6: While cyc is 1, the register and the output bit hold their value.
- R7: If a bus cycle contained at least one write, the first clock with cyc low loads the whole seed bank into the register. Shifting resumes on the clock after that.
- R8: If the seed bank is all zero when it is loaded, the register receives the default seed instead. The register is never zero.
- R9: A clock with cyc high and we low, or with cyc low, writes no seed byte and gives no ack. A bus cycle that contained no write causes no reload when it closes.
- R10: Seed bytes that are not written keep their previous value across bus cycles and reloads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_cyc_i | input | 1 | Bus cycle active |
| wb_stb_i | input | 1 | Transfer strobe |
| wb_we_i | input | 1 | Direction: 1 = write, 0 = read |
| wb_adr_i | input | 3 | Seed byte index |
| wb_dat_i | input | 8 | Seed byte value |
| wb_ack_o | output | 1 | Write completed (registered) |
| wb_stall_o | output | 1 | Busy indication, always low |
| rnd_bit_o | output | 1 | Pseudo-random output bit (register bit 63) |

## Verification
A wrong tap does not appear on the output until its feedback bit has travelled up to bit 63, which takes up to 64 clocks. For this reason, the free-running checks run well past 64 bits after each load. A byte written to the wrong seed position, or a reload that is missed or repeated, shows up on the output within 64 clocks after the bus cycle closes, because the first 64 output bits replay the seed MSB first. A missing hold during a bus cycle, or an ack in the wrong clock, shows up on the very next clock.

// File: rtl/lfsr_bitgen_pkg.sv
package lfsr_bitgen_pkg;

  // Register action chosen each clock by the bus front end.
  typedef enum logic [1:0] {
    CTL_RUN  = 2'd0,
    CTL_HOLD = 2'd1,
    CTL_LOAD = 2'd2
  } lfsr_ctl_e;

  // True when the current bus beat is a seed write.
  function automatic logic is_seed_write(input logic cyc, input logic stb, input logic we);
    return cyc & stb & we;
  endfunction

endpackage

// File: rtl/lfsr_wb_front.sv
module lfsr_wb_front
  import lfsr_bitgen_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      cyc_i,
  input  logic      stb_i,
  input  logic      we_i,
  output logic      wr_en_o,
  output lfsr_ctl_e ctl_o,
  output logic      ack_o,
  output logic      stall_o
);

  logic reload_pend_q;
  logic ack_q;
  logic stall_q;

  assign wr_en_o = is_seed_write(cyc_i, stb_i, we_i);

  // A write marks the bank dirty; the first idle clock consumes the mark.
  always_ff @(posedge clk) begin
    if (rst) begin
      reload_pend_q <= 1'b0;
    end else if (wr_en_o) begin
      reload_pend_q <= 1'b1;
    end else if (!cyc_i) begin
      reload_pend_q <= 1'b0;
    end
  end

  always_comb begin
    if (cyc_i) begin
      ctl_o = CTL_HOLD;
    end else if (reload_pend_q) begin
      ctl_o = CTL_LOAD;
    end else begin
      ctl_o = CTL_RUN;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q   <= 1'b0;
      stall_q <= 1'b0;
    end else begin
      ack_q   <= wr_en_o;
      stall_q <= 1'b0;
    end
  end

  assign ack_o   = ack_q;
  assign stall_o = stall_q;

  AST_ACK_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    (cyc_i && stb_i && we_i) |=> ack_o); // R4
  AST_NO_STRAY_ACK: assert property (@(posedge clk) disable iff (rst)
    !(cyc_i && stb_i && we_i) |=> !ack_o); // R9

endmodule

// File: rtl/lfsr_seed_bank.sv
module lfsr_seed_bank #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  localparam int NUM_BYTES = 1 << ADDR_W,
  localparam int SEED_W = DATA_W * NUM_BYTES,
  parameter logic [SEED_W-1:0] SEED_DEFAULT = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] adr_i,
  input  logic [DATA_W-1:0] dat_i,
  output logic [SEED_W-1:0] seed_o
);

  logic [SEED_W-1:0] bank_flat;

  // One register per byte lane so the whole seed is readable in parallel.
  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
    logic [DATA_W-1:0] lane_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        lane_q <= SEED_DEFAULT[g*DATA_W +: DATA_W];
      end else if (wr_en_i && (adr_i == ADDR_W'(g))) begin
        lane_q <= dat_i;
      end
    end
    assign bank_flat[g*DATA_W +: DATA_W] = lane_q;
  end

  // Lock-up guard: a zero seed is swapped for the default.
  assign seed_o = (bank_flat == '0) ? SEED_DEFAULT : bank_flat;

  AST_BANK_STABLE: assert property (@(posedge clk) disable iff (rst)
    !wr_en_i |=> $stable(bank_flat)); // R10

endmodule

// File: rtl/lfsr_shift_core.sv
module lfsr_shift_core
  import lfsr_bitgen_pkg::*;
#(
  parameter int WIDTH = 64,
  parameter logic [WIDTH-1:0] TAP_MASK = {2'b11, {(WIDTH-2){1'b0}}},
  parameter logic [WIDTH-1:0] SEED_DEFAULT = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  lfsr_ctl_e        ctl_i,
  input  logic [WIDTH-1:0] seed_i,
  output logic             bit_o
);

  logic [WIDTH-1:0] state_q;
  logic             feedback;

  assign feedback = ^(state_q & TAP_MASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEED_DEFAULT;
    end else begin
      unique case (ctl_i)
        CTL_HOLD: state_q <= state_q;
        CTL_LOAD: state_q <= seed_i;
        default:  state_q <= {state_q[WIDTH-2:0], feedback};
      endcase
    end
  end

  assign bit_o = state_q[WIDTH-1];

  AST_HOLD_IN_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (ctl_i == CTL_HOLD) |=> $stable(state_q)); // R6
  AST_LOAD_TAKES_SEED: assert property (@(posedge clk) disable iff (rst)
    (ctl_i == CTL_LOAD) |=> (state_q == $past(seed_i))); // R7
  AST_STATE_NONZERO: assert property (@(posedge clk) disable iff (rst)
    state_q != '0); // R8

endmodule

// File: rtl/lfsr_bitgen_wb.sv
module lfsr_bitgen_wb
  import lfsr_bitgen_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  parameter logic [(DATA_W << ADDR_W)-1:0] SEED_DEFAULT = 64'hC3A5_5A3C_9E37_79B9,
  parameter logic [(DATA_W << ADDR_W)-1:0] TAP_MASK = 64'hD800_0000_0000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wb_cyc_i,
  input  logic              wb_stb_i,
  input  logic              wb_we_i,
  input  logic [ADDR_W-1:0] wb_adr_i,
  input  logic [DATA_W-1:0] wb_dat_i,
  output logic              wb_ack_o,
  output logic              wb_stall_o,
  output logic              rnd_bit_o
);

  localparam int LFSR_W = DATA_W << ADDR_W;

  logic              wr_en;
  lfsr_ctl_e         ctl;
  logic [LFSR_W-1:0] seed_val;

  lfsr_wb_front u_front (
    .clk     (clk),
    .rst     (rst),
    .cyc_i   (wb_cyc_i),
    .stb_i   (wb_stb_i),
    .we_i    (wb_we_i),
    .wr_en_o (wr_en),
    .ctl_o   (ctl),
    .ack_o   (wb_ack_o),
    .stall_o (wb_stall_o)
  );

  lfsr_seed_bank #(
    .DATA_W       (DATA_W),
    .ADDR_W       (ADDR_W),
    .SEED_DEFAULT (SEED_DEFAULT)
  ) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en_i (wr_en),
    .adr_i   (wb_adr_i),
    .dat_i   (wb_dat_i),
    .seed_o  (seed_val)
  );

  lfsr_shift_core #(
    .WIDTH        (LFSR_W),
    .TAP_MASK     (TAP_MASK),
    .SEED_DEFAULT (SEED_DEFAULT)
  ) u_core (
    .clk    (clk),
    .rst    (rst),
    .ctl_i  (ctl),
    .seed_i (seed_val),
    .bit_o  (rnd_bit_o)
  );

endmodule

// File: tb/lfsr_bitgen_wb_bench.sv
module lfsr_bitgen_wb_bench;

  localparam logic [63:0] DEF_SEED = 64'hC3A5_5A3C_9E37_79B9;
  localparam int NVEC = 20;
  // Fields: {cyc, stb, we, adr[2:0], dat[7:0]}
  localparam logic [13:0] VEC [NVEC] = '{
    {3'b111, 3'd0, 8'h11}, {3'b111, 3'd1, 8'h22}, {3'b100, 3'd0, 8'h00},
    {3'b111, 3'd7, 8'hF0}, {3'b110, 3'd2, 8'h55}, {3'b000, 3'd0, 8'h00},
    {3'b000, 3'd0, 8'h00}, {3'b000, 3'd0, 8'h00}, {3'b000, 3'd0, 8'h00},
    {3'b000, 3'd0, 8'h00}, {3'b011, 3'd3, 8'h77}, {3'b000, 3'd0, 8'h00},
    {3'b110, 3'd4, 8'h99}, {3'b101, 3'd6, 8'h99}, {3'b000, 3'd0, 8'h00},
    {3'b000, 3'd0, 8'h00}, {3'b111, 3'd5, 8'h0A}, {3'b000, 3'd0, 8'h00},
    {3'b000, 3'd0, 8'h00}, {3'b000, 3'd0, 8'h00}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cyc = 1'b0, stb = 1'b0, we = 1'b0;
  logic [2:0] adr = '0;
  logic [7:0] dat = '0;
  logic       ack, stall, rbit;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [63:0] m_state;
  logic [7:0]  m_bank [8];
  bit          m_dirty;
  logic        m_ack;

  always #4 clk = ~clk;

  lfsr_bitgen_wb u_lfsr_bitgen_wb (
    .clk        (clk),
    .rst        (rst),
    .wb_cyc_i   (cyc),
    .wb_stb_i   (stb),
    .wb_we_i    (we),
    .wb_adr_i   (adr),
    .wb_dat_i   (dat),
    .wb_ack_o   (ack),
    .wb_stall_o (stall),
    .rnd_bit_o  (rbit)
  );

  function automatic logic [63:0] bank_word();
    logic [63:0] w;
    for (int i = 0; i < 8; i++) w[8*i +: 8] = m_bank[i];
    return w;
  endfunction

  task automatic check(input string tag);
    n_checks++;
    if (rbit !== m_state[63] || ack !== m_ack || stall !== 1'b0) begin
      n_fail++;
      $display("FAIL %s: bit/ack/stall actual %b%b%b expected %b%b0 at %0t",
               tag, rbit, ack, stall, m_state[63], m_ack, $time);
    end
  endtask

  task automatic step(input logic c, input logic s, input logic w,
                      input logic [2:0] a, input logic [7:0] d, input string tag);
    cyc = c; stb = s; we = w; adr = a; dat = d;
    @(posedge clk);
    m_ack = c & s & w;
    if (c) begin
      if (m_ack) begin
        m_bank[a] = d;
        m_dirty = 1'b1;
      end
    end else if (m_dirty) begin
      m_state = (bank_word() == 64'd0) ? DEF_SEED : bank_word();
      m_dirty = 1'b0;
    end else begin
      m_state = {m_state[62:0], m_state[63] ^ m_state[62] ^ m_state[60] ^ m_state[59]};
    end
    @(negedge clk);
    check(tag);
  endtask

  task automatic do_reset();
    rst = 1'b1; cyc = 0; stb = 0; we = 0; adr = '0; dat = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    m_state = DEF_SEED;
    for (int i = 0; i < 8; i++) m_bank[i] = DEF_SEED[8*i +: 8];
    m_dirty = 1'b0;
    m_ack = 1'b0;
    check("R1 reset state");
    rst = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R2: free run from the default seed well past 64 bits
    for (int i = 0; i < 80; i++) step(0, 0, 0, 3'd0, 8'h00, "R2 free run");

    // Vector table: R3 R4 R6 R7 R9 R10
    for (int i = 0; i < NVEC; i++)
      step(VEC[i][13], VEC[i][12], VEC[i][11], VEC[i][10:8], VEC[i][7:0],
           "R3 R4 R6 R7 R9 R10 vector");
    for (int i = 0; i < 70; i++) step(0, 0, 0, 3'd0, 8'h00, "R7 R10 run after load");

    // R8: all-zero seed falls back to default
    for (int i = 0; i < 8; i++) step(1, 1, 1, 3'(i), 8'h00, "R8 zero write");
    for (int i = 0; i < 70; i++) step(0, 0, 0, 3'd0, 8'h00, "R8 zero seed replaced");

    // R6: long hold with cyc high, no strobe
    for (int i = 0; i < 10; i++) step(1, 0, 1, 3'd2, 8'hFF, "R6 hold");
    step(0, 0, 0, 3'd0, 8'h00, "R9 no reload after empty cycle");

    // R1 R10: reset restores default bytes, then one lane rewritten
    do_reset();
    step(1, 1, 1, 3'd0, 8'h5A, "R3 single byte after reset");
    step(1, 1, 1, 3'd3, 8'hE4, "R4 back-to-back ack");
    for (int i = 0; i < 70; i++) step(0, 0, 0, 3'd0, 8'h00, "R10 default bytes kept");

    // R5 covered in every check; last sanity on stall
    n_checks++;
    if (stall !== 1'b0) begin
      n_fail++;
      $display("FAIL R5: stall actual %b expected 0", stall);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule